// File: doc/BRIEF.md
# Adapter Host-Interface Glue Registers

This block sits between an 8-bit host I/O window and the system-interface register file of a network controller. The host sees 16 byte offsets. Offsets 0x0 to 0x7 form a shared data window. Offsets 0x8, 0x9 and 0xF hold the glue's own control registers. A select bit routes the data window either to the controller or to an identity ROM. The ROM has two pages, and a page bit chooses between them.

Only eight controller registers fit in the window at one time. A bank bit supplies the fourth controller address line, which exposes controller registers 0x8 to 0xF at the same eight offsets. The controller's interrupt request is caught in a latch. That latch drives a level-sensitive host interrupt only while an enable bit is set. Software clears the latch by turning the enable off and then on again. The block also drives the controller reset, the ring-speed select and the cable-type select.

Top module: `hif_glue`

## Requirements
- R1: After reset, reg A (0x8) and reg B (0x9) read 0x00 and `ctl_rst_no` is low. `cable_utp_o` and `hst_irq_o` are low, the ROM is mapped and page zero is selected.
- R2: With reg A bit 2 = 0 and bit 3 = 0, window offsets read as follows: offset 0 gives `MFR_ID`, offset 1 gives `CARD_TYPE`, offset 2 gives `CARD_REV`, and offsets 3, 4, 5 give `cfg_i[7:0]`, `cfg_i[15:8]`, `cfg_i[23:16]`. Offsets 6 and 7 read 0x00.
- R3: With reg A bit 2 = 0 and bit 3 = 1, offsets 0 and 7 read 0x00. Offsets 1 to 6 return `STATION` one byte each, most significant byte at offset 1.
- R4: With reg A bit 2 = 1, a host read or write at offsets 0x0 to 0x7 asserts `ctl_cs_o` in that cycle. `ctl_we_o` equals the write strobe, `ctl_wdata_o` equals the host data, and `hst_rdata_o` returns `ctl_rdata_i`.
- R5: With reg A bit 2 = 0, `ctl_cs_o` and `ctl_we_o` stay low and host writes to the window reach no controller register.
- R6: `ctl_addr_o` is {reg B bit 2, host offset[2:0]}, so setting the bank bit reaches controller registers 0x8 to 0xF.
- R7: Reg A bit 1 is read-only and shows the interrupt latch. `hst_irq_o` is high only when the latch is set and reg B bit 3 (enable) is 1.
- R8: The latch sets in any cycle in which `ctl_irq_i` is high, whatever the enable. A write to reg B that changes the enable from 1 to 0 clears it. An event in that same cycle wins over the clear.
- R9: An event that arrives while the enable is 0 stays in the latch, and `hst_irq_o` rises when the enable is set again.
- R10: Reg B bit 0 drives `ctl_rst_no`, so a write of 0x00 to reg B holds the controller in reset. Reg B bit 1 drives `speed_hi_o` (1 = high speed).
- R11: A write to reg C (0xF) bit 0 drives `cable_utp_o` (1 = unshielded, 0 = shielded). Reg C reads back that bit in bit 0.
- R12: Reg A reads back bits 3:2 and reg B reads back bits 3:0. All other bits read 0, and offsets 0xA to 0xE read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hst_addr_i | input | 4 | Host byte offset |
| hst_rd_i | input | 1 | Host read strobe |
| hst_wr_i | input | 1 | Host write strobe |
| hst_wdata_i | input | 8 | Host write data |
| hst_rdata_o | output | 8 | Host read data (combinational) |
| hst_irq_o | output | 1 | Level interrupt to host |
| ctl_cs_o | output | 1 | Controller register select |
| ctl_we_o | output | 1 | Controller write enable |
| ctl_addr_o | output | 4 | Controller register address |
| ctl_wdata_o | output | 8 | Controller write data |
| ctl_rdata_i | input | 8 | Controller read data |
| ctl_irq_i | input | 1 | Controller interrupt event |
| ctl_rst_no | output | 1 | Controller reset, active low |
| speed_hi_o | output | 1 | Ring speed select |
| cable_utp_o | output | 1 | Cable type select |
| cfg_i | input | 24 | Configuration bytes mirrored in ROM page zero |

## Verification
The bench first targets the toggle-to-clear path. A latch that cleared when the enable rose would drop an event that arrived while the enable was low, so the host would never see that interrupt. A latch that cleared on any write to reg B would lose interrupts whenever speed or bank changed. The bench also drives an event in the same cycle as the clearing write; a design that let the clear win would miss that event. Bank writes are checked against distinct controller locations, where a dropped bank bit overwrites the lower register. Writes made with the ROM mapped must leave the controller model untouched.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int HA_W = 4;
  localparam int DW   = 8;
  localparam logic [HA_W-1:0] OFF_REGA = 4'h8;
  localparam logic [HA_W-1:0] OFF_REGB = 4'h9;
  localparam logic [HA_W-1:0] OFF_REGC = 4'hF;
  // reg A bits
  localparam int A_PEND = 1;
  localparam int A_SIF  = 2;
  localparam int A_PAGE = 3;
  // reg B bits
  localparam int B_NRST = 0;
  localparam int B_SPD  = 1;
  localparam int B_BANK = 2;
  localparam int B_IEN  = 3;

  typedef struct packed {
    logic sif_sel;
    logic page;
    logic nrst;
    logic speed;
    logic bank;
    logic ien;
    logic cable_utp;
  } ctrl_t;
endpackage

// File: rtl/hif_ctrl_regs.sv
module hif_ctrl_regs
  import hif_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic       wr_c_i,
  input  logic [3:0] wdata_i,
  input  logic       ev_i,
  output ctrl_t      ctrl_o,
  output logic       pend_o
);
  ctrl_t ctrl_q;
  logic  pend_q;
  logic  ien_fall;

  assign ien_fall = wr_b_i && ctrl_q.ien && !wdata_i[B_IEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_a_i) begin
        ctrl_q.sif_sel <= wdata_i[A_SIF];
        ctrl_q.page    <= wdata_i[A_PAGE];
      end
      if (wr_b_i) begin
        ctrl_q.nrst  <= wdata_i[B_NRST];
        ctrl_q.speed <= wdata_i[B_SPD];
        ctrl_q.bank  <= wdata_i[B_BANK];
        ctrl_q.ien   <= wdata_i[B_IEN];
      end
      if (wr_c_i) ctrl_q.cable_utp <= wdata_i[0];
    end
  end

  // event wins over the enable-off clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (ev_i)     pend_q <= 1'b1;
    else if (ien_fall) pend_q <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/hif_id_rom.sv
module hif_id_rom #(
  parameter logic [7:0]  MFR_ID    = 8'h4D,
  parameter logic [7:0]  CARD_TYPE = 8'h08,
  parameter logic [7:0]  CARD_REV  = 8'h02,
  parameter logic [47:0] STATION   = 48'h0000_0000_0000,
  parameter int          CFG_N     = 3
) (
  input  logic              page_i,
  input  logic [2:0]        off_i,
  input  logic [8*CFG_N-1:0] cfg_i,
  output logic [7:0]        data_o
);
  localparam int SA_N = 6;
  logic [7:0] pg0 [8];
  logic [7:0] pg1 [8];

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      pg0[i] = '0;
      pg1[i] = '0;
    end
    pg0[0] = MFR_ID;
    pg0[1] = CARD_TYPE;
    pg0[2] = CARD_REV;
    for (int i = 0; i < CFG_N; i++) pg0[3+i] = cfg_i[8*i +: 8];
    for (int i = 1; i <= SA_N; i++) pg1[i] = STATION[8*(SA_N-i) +: 8];
  end

  assign data_o = page_i ? pg1[off_i] : pg0[off_i];
endmodule

// File: rtl/hif_glue.sv
module hif_glue
  import hif_pkg::*;
#(
  parameter logic [7:0]  MFR_ID    = 8'h4D,
  parameter logic [7:0]  CARD_TYPE = 8'h08,
  parameter logic [7:0]  CARD_REV  = 8'h02,
  parameter logic [47:0] STATION   = 48'h4000_1234_5678
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [HA_W-1:0] hst_addr_i,
  input  logic            hst_rd_i,
  input  logic            hst_wr_i,
  input  logic [DW-1:0]   hst_wdata_i,
  output logic [DW-1:0]   hst_rdata_o,
  output logic            hst_irq_o,
  output logic            ctl_cs_o,
  output logic            ctl_we_o,
  output logic [HA_W-1:0] ctl_addr_o,
  output logic [DW-1:0]   ctl_wdata_o,
  input  logic [DW-1:0]   ctl_rdata_i,
  input  logic            ctl_irq_i,
  output logic            ctl_rst_no,
  output logic            speed_hi_o,
  output logic            cable_utp_o,
  input  logic [23:0]     cfg_i
);
  ctrl_t      ctrl;
  logic       pend_q;
  logic       sif_q, bank_q, ien_q;
  logic       in_win;
  logic [7:0] rom_d;

  assign in_win = !hst_addr_i[HA_W-1];

  hif_ctrl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_a_i  (hst_wr_i && hst_addr_i == OFF_REGA),
    .wr_b_i  (hst_wr_i && hst_addr_i == OFF_REGB),
    .wr_c_i  (hst_wr_i && hst_addr_i == OFF_REGC),
    .wdata_i (hst_wdata_i[3:0]),
    .ev_i    (ctl_irq_i),
    .ctrl_o  (ctrl),
    .pend_o  (pend_q)
  );

  hif_id_rom #(
    .MFR_ID    (MFR_ID),
    .CARD_TYPE (CARD_TYPE),
    .CARD_REV  (CARD_REV),
    .STATION   (STATION),
    .CFG_N     (3)
  ) u_rom (
    .page_i (ctrl.page),
    .off_i  (hst_addr_i[2:0]),
    .cfg_i  (cfg_i),
    .data_o (rom_d)
  );

  assign sif_q  = ctrl.sif_sel;
  assign bank_q = ctrl.bank;
  assign ien_q  = ctrl.ien;

  assign ctl_cs_o    = sif_q && in_win && (hst_rd_i || hst_wr_i);
  assign ctl_we_o    = ctl_cs_o && hst_wr_i;
  assign ctl_addr_o  = {bank_q, hst_addr_i[2:0]};
  assign ctl_wdata_o = hst_wdata_i;

  always_comb begin
    hst_rdata_o = '0;
    if (in_win) hst_rdata_o = sif_q ? ctl_rdata_i : rom_d;
    else begin
      unique case (hst_addr_i)
        OFF_REGA: begin
          hst_rdata_o[A_SIF]  = ctrl.sif_sel;
          hst_rdata_o[A_PAGE] = ctrl.page;
          hst_rdata_o[A_PEND] = pend_q;
        end
        OFF_REGB: begin
          hst_rdata_o[B_NRST] = ctrl.nrst;
          hst_rdata_o[B_SPD]  = ctrl.speed;
          hst_rdata_o[B_BANK] = ctrl.bank;
          hst_rdata_o[B_IEN]  = ctrl.ien;
        end
        OFF_REGC: hst_rdata_o[0] = ctrl.cable_utp;
        default:  hst_rdata_o = '0;
      endcase
    end
  end

  assign hst_irq_o   = pend_q && ien_q;
  assign ctl_rst_no  = ctrl.nrst;
  assign speed_hi_o  = ctrl.speed;
  assign cable_utp_o = ctrl.cable_utp;
endmodule

// File: rtl/hif_glue_chk.sv
module hif_glue_chk
  import hif_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hst_wr_i,
  input logic [HA_W-1:0] hst_addr_i,
  input logic [DW-1:0]   hst_wdata_i,
  input logic            ctl_irq_i,
  input logic            ctl_cs_o,
  input logic [HA_W-1:0] ctl_addr_o,
  input logic            hst_irq_o,
  input logic            ctl_rst_no,
  input logic            cable_utp_o,
  input logic            sif_q,
  input logic            bank_q,
  input logic            ien_q,
  input logic            pend_q
);
  AST_CS_NEEDS_SIF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_cs_o |-> sif_q); // R5

  AST_BANK_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_cs_o |-> (ctl_addr_o[HA_W-1] == bank_q)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_irq_o |-> ien_q); // R7

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_irq_i |=> pend_q); // R8

  AST_TOGGLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_wr_i && hst_addr_i == OFF_REGB && ien_q && !hst_wdata_i[B_IEN] && !ctl_irq_i)
    |=> !pend_q); // R8

  AST_RESET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_wr_i && hst_addr_i == OFF_REGB && hst_wdata_i == '0) |=> !ctl_rst_no); // R10

  AST_CABLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_wr_i && hst_addr_i == OFF_REGC) |=> (cable_utp_o == $past(hst_wdata_i[0]))); // R11
endmodule

bind hif_glue hif_glue_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hst_wr_i    (hst_wr_i),
  .hst_addr_i  (hst_addr_i),
  .hst_wdata_i (hst_wdata_i),
  .ctl_irq_i   (ctl_irq_i),
  .ctl_cs_o    (ctl_cs_o),
  .ctl_addr_o  (ctl_addr_o),
  .hst_irq_o   (hst_irq_o),
  .ctl_rst_no  (ctl_rst_no),
  .cable_utp_o (cable_utp_o),
  .sif_q       (sif_q),
  .bank_q      (bank_q),
  .ien_q       (ien_q),
  .pend_q      (pend_q)
);

// File: tb/hif_glue_bench.sv
`timescale 1ns/1ps
module hif_glue_bench;
  localparam logic [7:0]  T_MFR  = 8'h4D;
  localparam logic [7:0]  T_TYPE = 8'h0D;
  localparam logic [7:0]  T_REV  = 8'h03;
  localparam logic [47:0] T_SA   = 48'hA1B2_C3D4_E5F6;
  localparam logic [23:0] T_CFG  = 24'h96_5A_3C;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] hst_addr_i = '0;
  logic       hst_rd_i = 1'b0, hst_wr_i = 1'b0;
  logic [7:0] hst_wdata_i = '0;
  logic [7:0] hst_rdata_o;
  logic       hst_irq_o, ctl_cs_o, ctl_we_o;
  logic [3:0] ctl_addr_o;
  logic [7:0] ctl_wdata_o, ctl_rdata_i;
  logic       ctl_irq_i = 1'b0;
  logic       ctl_rst_no, speed_hi_o, cable_utp_o;
  logic [23:0] cfg_i = T_CFG;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] cmem [16];
  logic       wr_cs_seen;

  // reference state
  logic m_en = 0, m_latch = 0, m_nrst = 0, m_spd = 0, m_cab = 0;

  always #2.5 clk_i = ~clk_i;

  hif_glue #(.MFR_ID(T_MFR), .CARD_TYPE(T_TYPE), .CARD_REV(T_REV), .STATION(T_SA)) u_hif_glue (
    .clk_i, .rst_ni, .hst_addr_i, .hst_rd_i, .hst_wr_i, .hst_wdata_i, .hst_rdata_o,
    .hst_irq_o, .ctl_cs_o, .ctl_we_o, .ctl_addr_o, .ctl_wdata_o, .ctl_rdata_i,
    .ctl_irq_i, .ctl_rst_no, .speed_hi_o, .cable_utp_o, .cfg_i
  );

  // controller stand-in
  assign ctl_rdata_i = cmem[ctl_addr_o];
  initial for (int i = 0; i < 16; i++) cmem[i] = 8'(i * 17);
  always @(posedge clk_i) if (ctl_cs_o && ctl_we_o) cmem[ctl_addr_o] <= ctl_wdata_o;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // behavioural model, advanced on every edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_latch = 0; m_nrst = 0; m_spd = 0; m_cab = 0;
    end else begin
      if (ctl_irq_i) m_latch = 1;
      else if (hst_wr_i && hst_addr_i == 4'h9 && m_en && !hst_wdata_i[3]) m_latch = 0;
      if (hst_wr_i && hst_addr_i == 4'h9) begin
        m_nrst = hst_wdata_i[0]; m_spd = hst_wdata_i[1]; m_en = hst_wdata_i[3];
      end
      if (hst_wr_i && hst_addr_i == 4'hF) m_cab = hst_wdata_i[0];
    end
  end

  always @(negedge clk_i) begin
    cyc++;
    chk("R7 irq", {7'b0, hst_irq_o}, {7'b0, m_latch & m_en});
    chk("R10 rst", {7'b0, ctl_rst_no}, {7'b0, m_nrst});
    chk("R10 speed", {7'b0, speed_hi_o}, {7'b0, m_spd});
    chk("R11 cable", {7'b0, cable_utp_o}, {7'b0, m_cab});
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic ev = 1'b0);
    @(negedge clk_i);
    hst_addr_i = a; hst_wdata_i = d; hst_wr_i = 1'b1; ctl_irq_i = ev;
    #1 wr_cs_seen = ctl_cs_o;
    @(negedge clk_i);
    hst_wr_i = 1'b0; ctl_irq_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    hst_addr_i = a; hst_rd_i = 1'b1;
    #1 d = hst_rdata_o;
    hst_rd_i = 1'b0;
  endtask

  task automatic pulse_ev();
    @(negedge clk_i); ctl_irq_i = 1'b1;
    @(negedge clk_i); ctl_irq_i = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] exp0 [8];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(4'h8, d); chk("R1 regA", d, 8'h00);
    rd(4'h9, d); chk("R1 regB", d, 8'h00);
    chk("R1 rst_n", {7'b0, ctl_rst_no}, 8'h00);
    chk("R1 cable", {7'b0, cable_utp_o}, 8'h00);

    // R2 page zero
    exp0 = '{T_MFR, T_TYPE, T_REV, T_CFG[7:0], T_CFG[15:8], T_CFG[23:16], 8'h00, 8'h00};
    for (int i = 0; i < 8; i++) begin rd(4'(i), d); chk("R2 page0", d, exp0[i]); end

    // R5 window write with ROM mapped
    wr(4'h3, 8'hEE);
    chk("R5 cs low", {7'b0, wr_cs_seen}, 8'h00);
    chk("R5 ctl untouched", cmem[3], 8'h33);
    chk("R5 ctl untouched hi", cmem[11], 8'hBB);

    // R3 page one
    wr(4'h8, 8'h08);
    rd(4'h8, d); chk("R12 regA readback", d, 8'h08);
    rd(4'h0, d); chk("R3 off0", d, 8'h00);
    for (int i = 1; i <= 6; i++) begin rd(4'(i), d); chk("R3 station", d, T_SA[8*(6-i) +: 8]); end
    rd(4'h7, d); chk("R3 off7", d, 8'h00);

    // R10 reset/speed
    wr(4'h9, 8'h03);
    rd(4'h9, d); chk("R12 regB readback", d, 8'h03);
    chk("R10 released", {7'b0, ctl_rst_no}, 8'h01);
    wr(4'h9, 8'hF1);
    rd(4'h9, d); chk("R12 regB unused bits", d, 8'h01);
    rd(4'hA, d); chk("R12 unmapped", d, 8'h00);

    // R4 controller window
    wr(4'h8, 8'h04);
    wr(4'h3, 8'hA5);
    chk("R4 cs on write", {7'b0, wr_cs_seen}, 8'h01);
    chk("R4 ctl written", cmem[3], 8'hA5);
    rd(4'h3, d); chk("R4 ctl read", d, 8'hA5);

    // R6 bank switching
    wr(4'h9, 8'h05);
    wr(4'h3, 8'h5A);
    chk("R6 upper written", cmem[11], 8'h5A);
    chk("R6 lower kept", cmem[3], 8'hA5);
    rd(4'h3, d); chk("R6 upper read", d, 8'h5A);
    rd(4'h7, d); chk("R6 reg F", d, 8'hFF);
    wr(4'h9, 8'h01);
    rd(4'h3, d); chk("R6 lower read", d, 8'hA5);

    // R7/R9 event while disabled
    pulse_ev();
    rd(4'h8, d); chk("R7 status", d, 8'h06);
    chk("R7 gated", {7'b0, hst_irq_o}, 8'h00);
    wr(4'h9, 8'h09);
    chk("R9 raised", {7'b0, hst_irq_o}, 8'h01);

    // R8 toggle clears
    wr(4'h9, 8'h01);
    rd(4'h8, d); chk("R8 cleared", d, 8'h04);
    wr(4'h9, 8'h09);
    chk("R8 stays low", {7'b0, hst_irq_o}, 8'h00);
    wr(4'h9, 8'h0B);
    rd(4'h8, d); chk("R8 other write no clear", d, 8'h04);
    pulse_ev();
    chk("R8 set again", {7'b0, hst_irq_o}, 8'h01);
    wr(4'h9, 8'h0B);
    chk("R8 non-toggle keeps", {7'b0, hst_irq_o}, 8'h01);

    // R9 event between off and on
    wr(4'h9, 8'h01);
    pulse_ev();
    rd(4'h8, d); chk("R9 retained", d, 8'h06);
    wr(4'h9, 8'h09);
    chk("R9 after re-enable", {7'b0, hst_irq_o}, 8'h01);

    // R8 event coincides with clear
    wr(4'h9, 8'h01, 1'b1);
    rd(4'h8, d); chk("R8 set wins", d, 8'h06);
    wr(4'h9, 8'h09);
    chk("R8 set wins irq", {7'b0, hst_irq_o}, 8'h01);

    // R11 cable
    wr(4'hF, 8'h01);
    rd(4'hF, d); chk("R11 utp", d, 8'h01);
    wr(4'hF, 8'hFE);
    rd(4'hF, d); chk("R11 stp", d, 8'h00);

    // R10 hold in reset
    wr(4'h9, 8'h00);
    chk("R10 held", {7'b0, ctl_rst_no}, 8'h00);

    repeat (2) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule